// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block carries out the memory-resident context switch of a processor that keeps its general registers in memory, starting at a workspace pointer. It holds the live workspace pointer, program counter and status word. On request it runs one of three fixed sequences of word accesses on a single-port memory. Workspace register n sits at byte address WP + 2n.

A branch-with-new-workspace reads a two-word vector at a given source address. A numbered trap reads one of sixteen two-word vectors from a table at byte 0x0040. Both then store the outgoing WP, PC and ST in registers 13, 14 and 15 of the incoming workspace. A trap also stores the source address in register 11. A return reads registers 13, 14 and 15 of the current workspace back into WP, PC and ST.

The fetch and decode logic around the block raises `start` with the operation kind. It waits for `done`, then continues with the new context.

Top module: `ctx_switch_seq`

## Requirements
- R1: Reset clears WP, PC and ST to zero. It drives `busy`, `done`, `mem_rd` and `mem_wr` low.
- R2: Kind 0 (branch) loads WP from the word at `src_addr` and PC from the word at `src_addr`+2. ST does not change.
- R3: For kinds 0 and 1 the pre-switch WP, PC and ST are written to new WP+26, new WP+28 and new WP+30. WP, PC and ST stay unchanged while the sequence runs.
- R4: Kind 1 (trap) with 4-bit number c loads WP from byte 0x0040+4c and PC from 0x0042+4c. It writes `src_addr` to new WP+22. ST does not change.
- R5: Kind 2 (return) loads WP, PC and ST from current WP+26, WP+28 and WP+30.
- R6: Both vector reads complete before any write. Kind 0 makes exactly 2 reads and 3 writes, kind 1 makes 2 reads and 4 writes, and kind 2 makes 3 reads and no writes.
- R7: A pending access holds its address, strobe and write data until `mem_ready` is high. Read and write are never asserted together.
- R8: `done` is high for exactly one cycle, in the cycle after the final access completes. In that cycle `wp`, `pc` and `st` already show the new context.
- R9: `start` has no effect while `busy` is high. `start` with kind 3 has no effect either: no access, no change of context.
- R10: A `start` given in the cycle `done` is high is accepted. It operates on the context committed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a context switch |
| op_kind | input | 2 | 0 branch, 1 trap, 2 return, 3 invalid |
| src_addr | input | 16 | Effective source address |
| xop_num | input | 4 | Trap vector number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising `start` at the exact cycle `done` is seen high. It often chains a trap directly into a return. The follow-on operation must use the context committed in that cycle. A return chained after a trap must therefore restore precisely the pre-trap WP, PC and ST. The bench judges this against a model of memory and context that it updates itself, under randomly stalled `mem_ready`.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
// Shared types for the workspace context switch sequencer.
// Assumes word-aligned workspace pointers; addresses are byte addresses.
package ctx_pkg;
    typedef enum logic [1:0] {
        OPK_BRANCH = 2'd0,
        OPK_TRAP   = 2'd1,
        OPK_RETURN = 2'd2,
        OPK_NONE   = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_A, ST_RD_B, ST_RD_C,
        ST_WR_13, ST_WR_14, ST_WR_15, ST_WR_11
    } step_e;

    localparam int unsigned SLOT_OLD_WP = 13;
    localparam int unsigned SLOT_OLD_PC = 14;
    localparam int unsigned SLOT_OLD_ST = 15;
    localparam int unsigned SLOT_SRC    = 11;
endpackage

// File: rtl/ctx_fsm.sv
`timescale 1ns/1ps
// Step sequencer: walks the fixed access list for the latched operation kind,
// advancing one step per completed memory access.
// Assumes mem_ready completes the access presented in the same cycle.
module ctx_fsm
    import ctx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_kind_e kind_in,
    input  logic     mem_ready,
    output step_e    step,
    output op_kind_e kind_q,
    output logic     accept,
    output logic     finish,
    output logic     done,
    output logic     busy,
    output logic     mem_rd,
    output logic     mem_wr
);
    step_e step_nxt;

    // accept a request only from idle and only for a defined kind
    always_comb accept = start && (step == ST_IDLE) && (kind_in != OPK_NONE);

    // strobes and busy follow the current step
    always_comb begin
        busy   = (step != ST_IDLE);
        mem_rd = (step == ST_RD_A) || (step == ST_RD_B) || (step == ST_RD_C);
        mem_wr = (step == ST_WR_13) || (step == ST_WR_14) ||
                 (step == ST_WR_15) || (step == ST_WR_11);
    end

    // last access of the sequence completes this cycle
    always_comb finish = mem_ready && ((step == ST_RD_C) || (step == ST_WR_11) ||
                         ((step == ST_WR_15) && (kind_q != OPK_TRAP)));

    // next step selection
    always_comb begin
        step_nxt = step;
        case (step)
            ST_IDLE:  if (accept) step_nxt = ST_RD_A;
            ST_RD_A:  if (mem_ready) step_nxt = ST_RD_B;
            ST_RD_B:  if (mem_ready) step_nxt = (kind_q == OPK_RETURN) ? ST_RD_C : ST_WR_13;
            ST_RD_C:  if (mem_ready) step_nxt = ST_IDLE;
            ST_WR_13: if (mem_ready) step_nxt = ST_WR_14;
            ST_WR_14: if (mem_ready) step_nxt = ST_WR_15;
            ST_WR_15: if (mem_ready) step_nxt = (kind_q == OPK_TRAP) ? ST_WR_11 : ST_IDLE;
            ST_WR_11: if (mem_ready) step_nxt = ST_IDLE;
            default:  step_nxt = ST_IDLE;
        endcase
    end

    // state, latched kind and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= ST_IDLE;
            kind_q <= OPK_BRANCH;
            done   <= 1'b0;
        end else begin
            step <= step_nxt;
            if (accept) kind_q <= kind_in;
            done <= finish;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(mem_ready))); // R8
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(kind_q)); // R9
    AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_rd); // R6
endmodule

// File: rtl/ctx_addr.sv
`timescale 1ns/1ps
// Address and write-data generator: maps the current step to a byte address
// and store data. Purely combinational; assumes WP + 2n addressing.
module ctx_addr
    import ctx_pkg::*;
#(
    parameter int unsigned  W        = 16,
    parameter int unsigned  NUM_W    = 4,
    parameter logic [W-1:0] VEC_BASE = 16'h0040
) (
    input  step_e            step,
    input  op_kind_e         kind_q,
    input  logic [W-1:0]     src_q,
    input  logic [NUM_W-1:0] num_q,
    input  logic [W-1:0]     wp,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     st,
    input  logic [W-1:0]     new_wp,
    output logic [W-1:0]     addr,
    output logic [W-1:0]     wdata
);
    localparam logic [W-1:0] OFF_WP  = W'(2 * SLOT_OLD_WP);
    localparam logic [W-1:0] OFF_PC  = W'(2 * SLOT_OLD_PC);
    localparam logic [W-1:0] OFF_ST  = W'(2 * SLOT_OLD_ST);
    localparam logic [W-1:0] OFF_SRC = W'(2 * SLOT_SRC);
    localparam logic [W-1:0] WORD    = W'(2);

    logic [W-1:0] vec;
    logic         is_ret;

    // vector location: source address for branch, table slot for trap
    always_comb begin
        is_ret = (kind_q == OPK_RETURN);
        vec    = (kind_q == OPK_TRAP) ? (VEC_BASE + W'({num_q, 2'b00})) : src_q;
    end

    // per-step address and store data
    always_comb begin
        addr  = '0;
        wdata = '0;
        case (step)
            ST_RD_A:  addr = is_ret ? (wp + OFF_WP) : vec;
            ST_RD_B:  addr = is_ret ? (wp + OFF_PC) : (vec + WORD);
            ST_RD_C:  addr = wp + OFF_ST;
            ST_WR_13: begin addr = new_wp + OFF_WP;  wdata = wp;    end
            ST_WR_14: begin addr = new_wp + OFF_PC;  wdata = pc;    end
            ST_WR_15: begin addr = new_wp + OFF_ST;  wdata = st;    end
            ST_WR_11: begin addr = new_wp + OFF_SRC; wdata = src_q; end
            default:  begin addr = '0; wdata = '0; end
        endcase
    end
endmodule

// File: rtl/ctx_regs.sv
`timescale 1ns/1ps
// Context register bank: live WP/PC/ST, staging copies of the incoming
// WP/PC, and the request operands latched at acceptance. The live context
// changes only on the final access of a sequence.
module ctx_regs
    import ctx_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned NUM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [W-1:0]     src_in,
    input  logic [NUM_W-1:0] num_in,
    input  step_e            step,
    input  logic             mem_ready,
    input  logic [W-1:0]     rdata,
    input  logic             finish,
    output logic [W-1:0]     wp,
    output logic [W-1:0]     pc,
    output logic [W-1:0]     st,
    output logic [W-1:0]     new_wp,
    output logic [W-1:0]     src_q,
    output logic [NUM_W-1:0] num_q
);
    logic [W-1:0] new_pc;

    // latch operands, stage vector words, commit on the last access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; pc <= '0; st <= '0;
            new_wp <= '0; new_pc <= '0;
            src_q <= '0; num_q <= '0;
        end else begin
            if (accept) begin
                src_q <= src_in;
                num_q <= num_in;
            end
            if (mem_ready && (step == ST_RD_A)) new_wp <= rdata;
            if (mem_ready && (step == ST_RD_B)) new_pc <= rdata;
            if (finish) begin
                wp <= new_wp;
                pc <= new_pc;
                if (step == ST_RD_C) st <= rdata;
            end
        end
    end

    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((step != ST_IDLE) && !finish) |=> ($stable(wp) && $stable(pc) && $stable(st))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((step == ST_IDLE) && !accept) |=> ($stable(wp) && $stable(pc) && $stable(st))); // R9
endmodule

// File: rtl/ctx_switch_seq.sv
`timescale 1ns/1ps
// Workspace context switch sequencer top: joins the step sequencer, the
// address generator and the register bank. Assumes a single-port word
// memory that completes the presented access when mem_ready is high.
module ctx_switch_seq
    import ctx_pkg::*;
#(
    parameter int unsigned  W        = 16,
    parameter int unsigned  NUM_W    = 4,
    parameter logic [W-1:0] VEC_BASE = 16'h0040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op_kind,
    input  logic [W-1:0]     src_addr,
    input  logic [NUM_W-1:0] xop_num,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     wp,
    output logic [W-1:0]     pc,
    output logic [W-1:0]     st,
    output logic [W-1:0]     mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    input  logic             mem_ready
);
    step_e            step;
    op_kind_e         kind_q;
    logic             accept, finish;
    logic [W-1:0]     new_wp, src_q;
    logic [NUM_W-1:0] num_q;

    ctx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .kind_in(op_kind_e'(op_kind)),
        .mem_ready(mem_ready), .step(step), .kind_q(kind_q), .accept(accept),
        .finish(finish), .done(done), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    ctx_addr #(.W(W), .NUM_W(NUM_W), .VEC_BASE(VEC_BASE)) u_addr (
        .step(step), .kind_q(kind_q), .src_q(src_q), .num_q(num_q),
        .wp(wp), .pc(pc), .st(st), .new_wp(new_wp),
        .addr(mem_addr), .wdata(mem_wdata)
    );

    ctx_regs #(.W(W), .NUM_W(NUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .src_in(src_addr), .num_in(xop_num),
        .step(step), .mem_ready(mem_ready), .rdata(mem_rdata), .finish(finish),
        .wp(wp), .pc(pc), .st(st), .new_wp(new_wp), .src_q(src_q), .num_q(num_q)
    );

    AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready) |=>
        ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata))); // R7
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R7
endmodule

// File: tb/ctx_switch_seq_test.sv
`timescale 1ns/1ps
module ctx_switch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [15:0] src_addr = 16'd0;
    logic [3:0]  xop_num = 4'd0;
    logic        busy, done, mem_rd, mem_wr;
    logic [15:0] wp, pc, st, mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    ctx_switch_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .src_addr(src_addr), .xop_num(xop_num), .busy(busy), .done(done),
        .wp(wp), .pc(pc), .st(st), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    // bench memory: 1024 words, byte address bits [10:1]
    logic [15:0] mem [0:1023];
    logic        pk_we = 1'b0;
    logic [9:0]  pk_a = '0;
    logic [15:0] pk_d = '0;

    function automatic logic [9:0] idx(input logic [15:0] a);
        return a[10:1];
    endfunction
    function automatic logic [15:0] slot(input logic [15:0] base, input int n);
        return base + 16'(2 * n);
    endfunction
    function automatic logic [15:0] vec_addr(input logic [1:0] k, input logic [15:0] s,
                                             input logic [3:0] c);
        return (k == 2'd1) ? (16'h0040 + {10'd0, c, 2'b00}) : s;
    endfunction
    function automatic logic [15:0] rand_wp();
        return 16'h0200 + 16'(($urandom % 32'h2E0) * 2);
    endfunction

    assign mem_rdata = mem[idx(mem_addr)];

    always @(posedge clk) begin
        if (pk_we) mem[pk_a] <= pk_d;
        else if (mem_wr && mem_ready) mem[idx(mem_addr)] <= mem_wdata;
    end

    logic stall_all = 1'b0;
    always @(negedge clk) mem_ready = stall_all ? 1'b0 : (($urandom % 4) != 0);

    // access monitor
    logic        mon_clr = 1'b0;
    int          n_rd = 0, n_wr = 0, order_bad = 0, hold_bad = 0, cyc = 0, last_cyc = 0;
    logic        p_act = 1'b0, p_rdy = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
    logic [15:0] p_addr = '0, p_wd = '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            n_rd <= 0; n_wr <= 0; order_bad <= 0; hold_bad <= 0;
        end else begin
            if (mem_ready && mem_rd) begin
                n_rd <= n_rd + 1;
                if (n_wr != 0) order_bad <= 1;
            end
            if (mem_ready && mem_wr) n_wr <= n_wr + 1;
            if ((p_act && !p_rdy && (mem_addr != p_addr || mem_rd != p_rd || mem_wr != p_wr ||
                 (mem_wr && mem_wdata != p_wd))) || (mem_rd && mem_wr))
                hold_bad <= hold_bad + 1;
        end
        if (mem_ready && (mem_rd || mem_wr)) last_cyc <= cyc;
        p_act <= mem_rd || mem_wr; p_rdy <= mem_ready; p_rd <= mem_rd; p_wr <= mem_wr;
        p_addr <= mem_addr; p_wd <= mem_wdata;
    end

    int checks = 0, errors = 0;
    logic [15:0] e_wp = '0, e_pc = '0, e_st = '0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); pk_we = 1'b1; pk_a = idx(a); pk_d = d;
        @(negedge clk); pk_we = 1'b0;
    endtask

    // run one operation; imm: start in the current cycle; chain: next op starts in done cycle
    task automatic do_op(input logic [1:0] k, input logic [15:0] s, input logic [3:0] c,
                         input bit imm, input bit chain, input bit disturb);
        logic [15:0] va, nwp, npc, nst;
        int n;
        string tg;
        if (!imm) @(negedge clk);
        tg = (k == 2'd0) ? "R2" : (k == 2'd1) ? "R4" : "R5";
        if (imm) tg = {tg, "/R10"};
        va = vec_addr(k, s, c);
        if (k == 2'd2) begin
            nwp = mem[idx(slot(e_wp, 13))]; npc = mem[idx(slot(e_wp, 14))];
            nst = mem[idx(slot(e_wp, 15))];
        end else begin
            nwp = mem[idx(va)]; npc = mem[idx(va + 16'd2)]; nst = e_st;
        end
        start = 1'b1; op_kind = k; src_addr = s; xop_num = c; mon_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; mon_clr = 1'b0; op_kind = 2'($urandom); src_addr = 16'($urandom);
        xop_num = 4'($urandom);
        if (disturb) begin
            @(negedge clk);
            start = 1'b1; op_kind = 2'd1; xop_num = 4'd5; src_addr = 16'h1234;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
        if (!done) begin
            check(tg, "timeout waiting for done", 0, 1);
            return;
        end
        check(tg, "wp", wp, nwp);
        check(tg, "pc", pc, npc);
        check(tg, "st", st, nst);
        if (k != 2'd2) begin
            check("R3", "saved wp", mem[idx(slot(nwp, 13))], e_wp);
            check("R3", "saved pc", mem[idx(slot(nwp, 14))], e_pc);
            check("R3", "saved st", mem[idx(slot(nwp, 15))], e_st);
        end
        if (k == 2'd1) check("R4", "saved source", mem[idx(slot(nwp, 11))], s);
        check(disturb ? "R9" : "R6", "read count", n_rd, (k == 2'd2) ? 3 : 2);
        check(disturb ? "R9" : "R6", "write count", n_wr, (k == 2'd0) ? 3 : (k == 2'd1) ? 4 : 0);
        check("R6", "read after write", order_bad, 0);
        check("R7", "access hold", hold_bad, 0);
        check("R8", "done timing", cyc, last_cyc + 1);
        e_wp = nwp; e_pc = npc; e_st = nst;
        if (!chain) begin
            @(negedge clk);
            check("R8", "done width", done, 0);
            check(disturb ? "R9" : "R8", "idle after done", busy, 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "wp", wp, 0); check("R1", "pc", pc, 0); check("R1", "st", st, 0);
        check("R1", "busy", busy, 0); check("R1", "done", done, 0);
        check("R1", "strobes", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 16; c++) begin
            poke(16'h0040 + 16'(4 * c), rand_wp());
            poke(16'h0042 + 16'(4 * c), 16'($urandom));
        end
        for (int b = 0; b < 16; b++) begin
            poke(16'h00C0 + 16'(4 * b), rand_wp());
            poke(16'h00C2 + 16'(4 * b), 16'($urandom));
        end
        // directed cases
        do_op(2'd0, 16'h00C0, 4'd0, 0, 0, 0);
        poke(slot(e_wp, 15), 16'hA5C3);
        do_op(2'd1, 16'hBEEF, 4'd0, 0, 0, 0);
        do_op(2'd1, 16'h0101, 4'd15, 0, 0, 0);
        do_op(2'd2, 16'h0, 4'd0, 0, 0, 0);
        do_op(2'd2, 16'h0, 4'd0, 0, 0, 0);
        // R9: start while busy is ignored
        do_op(2'd0, 16'h00C4, 4'd0, 0, 0, 1);
        // R9: invalid kind is ignored
        @(negedge clk);
        start = 1'b1; op_kind = 2'd3; mon_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; mon_clr = 1'b0;
        repeat (4) @(negedge clk);
        check("R9", "busy after kind 3", busy, 0);
        check("R9", "accesses after kind 3", n_rd + n_wr, 0);
        check("R9", "wp after kind 3", wp, e_wp);
        check("R9", "pc after kind 3", pc, e_pc);
        // R10: trap chained into return in the done cycle
        do_op(2'd1, 16'h7777, 4'd7, 0, 1, 0);
        do_op(2'd2, 16'h0, 4'd0, 1, 0, 0);
        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [1:0] k;
            bit ch;
            k = 2'($urandom % 3);
            ch = (($urandom % 4) == 0);
            do_op(k, 16'h00C0 + 16'(4 * ($urandom % 16)), 4'($urandom), 0, ch, 0);
            if (ch) do_op(2'($urandom % 3), 16'h00C0 + 16'(4 * ($urandom % 16)),
                          4'($urandom), 1, 0, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule